// File: doc/BRIEF.md
# Idle-Timed Refresh Rate Switcher

This controller picks one of two refresh rates for an internal display panel from the amount of screen activity. Each display plane can report that it is being drawn to (an invalidate pulse) or that its pending drawing has been pushed out (a flush pulse). The controller records which planes are dirty in a busy mask. Any invalidate returns the panel to the high rate on the next clock. Once every plane has been flushed and the screen then stays quiet for a fixed idle period, the controller selects the low rate.

The rate change is seamless: the block drives a rate-select level and a one-cycle switch strobe toward the timing generator, which reprograms its timing without a full mode change. A capability input says whether the panel has a low-rate mode at all, and an enable input turns the feature on or off. Only the two rates are handled. The idle period is a parameter counted in clock cycles, and its default is one second of a 50 MHz clock.

Top module: `refresh_rate_ctrl`

## Requirements
- R1: When `enable` is 1 and `inval_mask` is nonzero at a clock edge, `rate_low` is 0 after that edge.
- R2: A 1 bit in `inval_mask` marks that plane busy. A 1 bit in `flush_mask` marks it idle again. `rate_low` can rise only while no plane is busy.
- R3: A flush that leaves every plane idle starts the idle timer. If neither an invalidate nor a disable arrives in between, `rate_low` becomes 1 exactly `IDLE_CYCLES` clock edges after the edge that took the flush.
- R4: While `lowrate_capable` is 0, `rate_low` is 0 after every edge. If the capability drops while the low rate is selected, the high rate returns on the next edge.
- R5: A flush that leaves any plane still busy does not start the idle timer, so the rate stays high.
- R6: When `enable` is 0 at an edge, the busy mask is cleared, a pending idle timer is cancelled, and `rate_low` is 0.
- R7: `rate_switch` is high for exactly the one cycle in which `rate_low` has just changed. A request for the rate already selected gives no strobe, and this includes a timer that expires while the low rate is already selected.
- R8: When the same plane gets an invalidate and a flush in the same cycle, the invalidate wins and the plane stays busy.
- R9: An invalidate during the idle countdown cancels the countdown. The low rate can follow only after a later flush leaves every plane idle and a full new idle period passes.
- R10: After the synchronous reset, `rate_low` is 0, `rate_switch` is 0 and no plane is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Turns rate switching on. When 0, the block forces the high rate and clears its state |
| lowrate_capable | input | 1 | 1 when the panel supports the low-rate mode |
| inval_mask | input | NUM_PLANES | Per-plane invalidate pulses; a 1 bit marks that plane busy |
| flush_mask | input | NUM_PLANES | Per-plane flush pulses; a 1 bit marks that plane idle |
| rate_low | output | 1 | Selected rate: 1 for the low rate, 0 for the high rate |
| rate_switch | output | 1 | One-cycle strobe in the cycle after `rate_low` changes |

## Verification
Internal state shows at the ports only through the rate output. A busy bit that is wrongly kept or wrongly lost appears as a low-rate entry that is missed or that comes too early, one full idle period after the flush that should or should not have armed the timer. An off-by-one in the idle counter shifts the rising edge of `rate_low` by one cycle. The bench therefore checks that edge to the exact cycle. A wrong strobe condition shows up in the same cycle as the rate change, or as a spurious strobe when the timer expires while the low rate is already selected.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  typedef enum logic {
    RATE_HIGH = 1'b0,
    RATE_LOW  = 1'b1
  } rate_e;

  function automatic int unsigned cnt_width(input int unsigned cycles);
    return (cycles > 1) ? $clog2(cycles) : 1;
  endfunction

endpackage

// File: rtl/rrs_busy_tracker.sv
module rrs_busy_tracker #(
  parameter int unsigned NUM_PLANES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_all,
  input  logic [NUM_PLANES-1:0] set_mask,
  input  logic [NUM_PLANES-1:0] done_mask,
  output logic [NUM_PLANES-1:0] busy_q,
  output logic [NUM_PLANES-1:0] busy_d
);

  // A set request overrides a done request for the same plane.
  always_comb begin
    if (clr_all) busy_d = '0;
    else         busy_d = (busy_q & ~done_mask) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= '0;
    else     busy_q <= busy_d;
  end

endmodule

// File: rtl/rrs_idle_timer.sv
module rrs_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic cancel,
  input  logic start,
  output logic expire
);
  import rrs_pkg::*;

  localparam int unsigned CNT_W = cnt_width(IDLE_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYCLES - 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  assign expire = armed_q && (cnt_q == LAST) && !cancel && !start;

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (cnt_q == LAST) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rrs_rate_select.sv
module rrs_rate_select (
  input  logic clk,
  input  logic rst,
  input  logic force_high,
  input  logic go_low,
  output logic rate_low,
  output logic rate_switch
);
  import rrs_pkg::*;

  rate_e rate_q, rate_d;
  logic  sw_q;

  always_comb begin
    if (force_high)  rate_d = RATE_HIGH;
    else if (go_low) rate_d = RATE_LOW;
    else             rate_d = rate_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= RATE_HIGH;
      sw_q   <= 1'b0;
    end else begin
      rate_q <= rate_d;
      sw_q   <= (rate_d != rate_q);
    end
  end

  assign rate_low    = (rate_q == RATE_LOW);
  assign rate_switch = sw_q;

endmodule

// File: rtl/refresh_rate_ctrl.sv
module refresh_rate_ctrl #(
  parameter int unsigned NUM_PLANES  = 4,
  parameter int unsigned IDLE_CYCLES = 50_000_000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  logic                  lowrate_capable,
  input  logic [NUM_PLANES-1:0] inval_mask,
  input  logic [NUM_PLANES-1:0] flush_mask,
  output logic                  rate_low,
  output logic                  rate_switch
);

  logic [NUM_PLANES-1:0] busy_q;
  logic [NUM_PLANES-1:0] busy_d;
  logic                  inval_any;
  logic                  arm;
  logic                  expire;

  assign inval_any = enable && (|inval_mask);
  assign arm       = enable && !inval_any && (|flush_mask) && (busy_d == '0);

  rrs_busy_tracker #(.NUM_PLANES(NUM_PLANES)) u_busy (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (!enable),
    .set_mask  (inval_mask),
    .done_mask (flush_mask),
    .busy_q    (busy_q),
    .busy_d    (busy_d)
  );

  rrs_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .cancel (!enable || inval_any),
    .start  (arm),
    .expire (expire)
  );

  rrs_rate_select u_rate (
    .clk         (clk),
    .rst         (rst),
    .force_high  (!enable || !lowrate_capable || inval_any),
    .go_low      (expire && lowrate_capable),
    .rate_low    (rate_low),
    .rate_switch (rate_switch)
  );

endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int unsigned NUM_PLANES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  enable,
  input logic                  lowrate_capable,
  input logic [NUM_PLANES-1:0] inval_mask,
  input logic [NUM_PLANES-1:0] flush_mask,
  input logic                  rate_low,
  input logic                  rate_switch,
  input logic [NUM_PLANES-1:0] busy
);

  AST_INVAL_FORCES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (enable && (inval_mask != '0)) |=> !rate_low); // R1

  AST_LOW_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(rate_low) |-> (busy == '0)); // R2

  AST_NOCAP_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
    !lowrate_capable |=> !rate_low); // R4

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!rate_low && (busy == '0))); // R6

  AST_STROBE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    rate_switch |-> (rate_low != $past(rate_low))); // R7

  AST_CHANGE_GIVES_STROBE: assert property (@(posedge clk) disable iff (rst)
    (rate_low != $past(rate_low)) |-> rate_switch); // R7

  AST_INVAL_BEATS_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (enable && ((inval_mask & flush_mask) != '0)) |=>
      ((busy & $past(inval_mask & flush_mask)) == $past(inval_mask & flush_mask))); // R8

endmodule

bind refresh_rate_ctrl rrs_checker #(.NUM_PLANES(NUM_PLANES)) u_rrs_checker (
  .clk             (clk),
  .rst             (rst),
  .enable          (enable),
  .lowrate_capable (lowrate_capable),
  .inval_mask      (inval_mask),
  .flush_mask      (flush_mask),
  .rate_low        (rate_low),
  .rate_switch     (rate_switch),
  .busy            (u_busy.busy_q)
);

// File: tb/tb_refresh_rate_ctrl.sv
`timescale 1ns/1ps
module tb_refresh_rate_ctrl;

  localparam int NP   = 4;
  localparam int IDLE = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          cap = 1'b1;
  logic [NP-1:0] inval_mask = '0;
  logic [NP-1:0] flush_mask = '0;
  logic          rate_low;
  logic          rate_switch;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R10";

  // behavioural reference state
  logic [NP-1:0] m_busy;
  int            m_rem;
  bit            m_low, m_sw;

  always #10 clk = ~clk;

  refresh_rate_ctrl #(.NUM_PLANES(NP), .IDLE_CYCLES(IDLE)) dut (
    .clk(clk), .rst(rst), .enable(enable), .lowrate_capable(cap),
    .inval_mask(inval_mask), .flush_mask(flush_mask),
    .rate_low(rate_low), .rate_switch(rate_switch)
  );

  task automatic check(input string req, input bit act_low, input bit act_sw,
                       input bit exp_low, input bit exp_sw);
    checks++;
    if (act_low !== exp_low || act_sw !== exp_sw) begin
      fails++;
      $display("FAIL %s: rate_low/rate_switch = %0b/%0b, expected %0b/%0b",
               req, act_low, act_sw, exp_low, exp_sw);
    end
  endtask

  task automatic model_step();
    bit old_low = m_low;
    bit fire = 0;
    if (!enable) begin
      m_busy = '0;
      m_rem  = -1;
    end else begin
      m_busy = (m_busy & ~flush_mask) | inval_mask;
      if (inval_mask != '0) m_rem = -1;
      else if (flush_mask != '0 && m_busy == '0) m_rem = IDLE;
      else if (m_rem > 0) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin fire = 1; m_rem = -1; end
      end
    end
    if (!enable || !cap || inval_mask != '0) m_low = 0;
    else if (fire) m_low = 1;
    m_sw = (m_low != old_low);
  endtask

  task automatic cyc(input logic [NP-1:0] inv, input logic [NP-1:0] fl);
    inval_mask = inv;
    flush_mask = fl;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, rate_low, rate_switch, m_low, m_sw);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_busy = '0; m_rem = -1; m_low = 0; m_sw = 0;
    repeat (3) @(negedge clk);
    tag = "R10";
    check("R10", rate_low, rate_switch, 1'b0, 1'b0);
    rst = 1'b0;
    enable = 1'b1;

    // R3: exact idle timeout after the last flush
    tag = "R3";
    cyc(4'b0001, '0);
    cyc('0, 4'b0001);
    idle(IDLE - 1);
    check("R3", rate_low, rate_switch, 1'b0, 1'b0);
    cyc('0, '0);
    check("R3", rate_low, rate_switch, 1'b1, 1'b1);
    cyc('0, '0);
    check("R7", rate_low, rate_switch, 1'b1, 1'b0);

    // R1: invalidate returns to high at once
    tag = "R1";
    cyc(4'b0010, '0);
    check("R1", rate_low, rate_switch, 1'b0, 1'b1);
    tag = "R7";
    cyc(4'b0010, '0);
    check("R7", rate_low, rate_switch, 1'b0, 1'b0);

    // R5 / R2: a partial flush keeps the timer idle
    tag = "R5";
    cyc(4'b0100, '0);
    cyc('0, 4'b0010);
    idle(IDLE + 4);
    check("R5", rate_low, rate_switch, 1'b0, 1'b0);
    tag = "R2";
    cyc('0, 4'b0100);
    idle(IDLE);
    check("R2", rate_low, rate_switch, 1'b1, 1'b1);

    // R9: an invalidate during the countdown restarts it
    tag = "R9";
    cyc(4'b1000, '0);
    cyc('0, 4'b1000);
    idle(8);
    cyc(4'b0001, '0);
    idle(IDLE + 4);
    check("R9", rate_low, rate_switch, 1'b0, 1'b0);
    cyc('0, 4'b0001);
    idle(IDLE);
    check("R9", rate_low, rate_switch, 1'b1, 1'b1);

    // R8: an invalidate and a flush on the same plane
    tag = "R8";
    cyc(4'b0001, 4'b0001);
    check("R1", rate_low, rate_switch, 1'b0, 1'b1);
    idle(IDLE + 4);
    check("R8", rate_low, rate_switch, 1'b0, 1'b0);
    cyc('0, 4'b0001);
    idle(IDLE);
    check("R8", rate_low, rate_switch, 1'b1, 1'b1);

    // R6: disable cancels the timer and clears the busy mask
    tag = "R6";
    cyc(4'b0011, '0);
    cyc('0, 4'b0011);
    idle(5);
    cyc(4'b0001, '0);
    enable = 1'b0;
    cyc('0, '0);
    check("R6", rate_low, rate_switch, 1'b0, 1'b0);
    enable = 1'b1;
    idle(IDLE + 4);
    check("R6", rate_low, rate_switch, 1'b0, 1'b0);
    cyc('0, 4'b0010);
    idle(IDLE);
    check("R6", rate_low, rate_switch, 1'b1, 1'b1);

    // R4: capability dropped while low, and the timer without capability
    tag = "R4";
    cap = 1'b0;
    cyc('0, '0);
    check("R4", rate_low, rate_switch, 1'b0, 1'b1);
    cyc('0, 4'b0001);
    idle(IDLE + 4);
    check("R4", rate_low, rate_switch, 1'b0, 1'b0);
    cap = 1'b1;
    cyc('0, 4'b0001);
    idle(IDLE);
    check("R4", rate_low, rate_switch, 1'b1, 1'b1);

    // R7: the timer expires while already low, so no strobe
    tag = "R7";
    cyc('0, 4'b0100);
    idle(IDLE + 2);
    check("R7", rate_low, rate_switch, 1'b1, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule